// File: doc/BRIEF.md
# VGA Compatible Address Forwarding Decoder

This block sits on the primary side of a bus bridge. For each request it decides whether the request targets the fixed legacy VGA windows. The memory window is the display frame-buffer range. The I/O window is the set of display-controller port blocks, which may appear at ISA alias positions. The block then says whether a primary-originated request is forwarded to the secondary side, or whether a secondary-originated request is kept from crossing upstream.

Software controls the decision through two bits. The VGA enable bit turns the whole mechanism on or off. The 16-bit decode bit chooses between alias-tolerant and exact I/O matching. The command-register I/O and memory enables further qualify each forwarded request. The bridge's other windows (base/limit ranges and ISA mode) are not inputs to this block and do not affect its decision.

Both results are registered. They appear in the cycle after the request strobe and stay low whenever no request was presented.

Top module: `vga_fwd_decoder`

## Requirements
- R1: A memory request (`req_is_io` = 0) matches only when its address lies between 000A_0000h and 000B_FFFFh, both ends included.
- R2: An I/O request (`req_is_io` = 1) can match only when address bits [31:16] are all zero.
- R3: An I/O request matches only when address bits [9:0] fall in 3B0h..3BBh or 3C0h..3DFh, both ranges inclusive.
- R4: With `vga_dec16` = 0, address bits [15:10] of an I/O request are not examined, so every alias of a listed port matches.
- R5: With `vga_dec16` = 1, an I/O request matches only when address bits [15:10] are zero.
- R6: A matching primary-originated request (`req_from_sec` = 0) raises `fwd_down` only if the enable for its kind is set: `cmd_io_en` for I/O and `cmd_mem_en` for memory.
- R7: With `vga_en` = 0, neither output is raised for any request, whatever the values of `vga_dec16` and the command enables.
- R8: A matching secondary-originated request (`req_from_sec` = 1) with `vga_en` = 1 raises `block_up` regardless of the command enables, and never raises `fwd_down`. The two outputs are never high together.
- R9: Outputs are registered: a request presented in the cycle ending at clock edge N shows its result after edge N. A cycle with `req_valid` = 0 gives both outputs low after the next edge, and both are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe for this cycle |
| req_addr | input | ADDR_W | Request address |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_from_sec | input | 1 | 1 = request came from the secondary side |
| vga_en | input | 1 | VGA window forwarding on |
| vga_dec16 | input | 1 | 1 = I/O alias bits [15:10] must be zero |
| cmd_io_en | input | 1 | Command-register I/O enable |
| cmd_mem_en | input | 1 | Command-register memory enable |
| fwd_down | output | 1 | Registered: forward request primary to secondary |
| block_up | output | 1 | Registered: stop request from going secondary to primary |

## Verification
The only state in the block is the pair of output flops. A wrong decode or gating term therefore shows at the ports exactly one clock after the request that exposes it; nothing is hidden for longer than that cycle. The vectors sit on each window edge and on both sides of each edge. They walk the alias bits with 16-bit decoding on and off, and they toggle each enable alone, so that a flipped comparison or a swapped enable produces a wrong flag on the very next edge.

// File: rtl/vga_fwd_pkg.sv
package vga_fwd_pkg;

   // Legacy frame-buffer window (inclusive)
   localparam logic [31:0] MEM_WIN_LO = 32'h000A_0000;
   localparam logic [31:0] MEM_WIN_HI = 32'h000B_FFFF;

   // Port-offset width inside one alias block
   localparam int unsigned PORT_OFS_W = 10;

   // Port blocks decoded inside each alias (inclusive bounds)
   localparam int unsigned IO_BLK_N = 2;
   localparam logic [PORT_OFS_W-1:0] IO_BLK_LO [IO_BLK_N] = '{10'h3B0, 10'h3C0};
   localparam logic [PORT_OFS_W-1:0] IO_BLK_HI [IO_BLK_N] = '{10'h3BB, 10'h3DF};

   typedef struct packed {
      logic fwd;
      logic blk;
   } vga_verdict_t;

endpackage

// File: rtl/vga_mem_window.sv
module vga_mem_window #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   import vga_fwd_pkg::*;

   localparam logic [ADDR_W-1:0] LO = ADDR_W'(MEM_WIN_LO);
   localparam logic [ADDR_W-1:0] HI = ADDR_W'(MEM_WIN_HI);

   generate
      if (ADDR_W < 20) begin : g_bad_width
         $error("vga_mem_window: ADDR_W must cover the frame-buffer window");
      end
   endgenerate

   always_comb begin
      hit = (addr >= LO) && (addr <= HI);
   end

endmodule

// File: rtl/vga_io_window.sv
module vga_io_window #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PORT_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              dec16,
   output logic              hit
);
   import vga_fwd_pkg::*;

   localparam int unsigned ALIAS_W = PORT_W - PORT_OFS_W;
   localparam int unsigned UPPER_W = ADDR_W - PORT_W;

   generate
      if (PORT_W <= PORT_OFS_W) begin : g_bad_port
         $error("vga_io_window: PORT_W must exceed the port-offset width");
      end
      if (ADDR_W <= PORT_W) begin : g_bad_addr
         $error("vga_io_window: ADDR_W must exceed PORT_W");
      end
   endgenerate

   logic [PORT_OFS_W-1:0] ofs;
   logic [ALIAS_W-1:0]    alias_bits;
   logic [UPPER_W-1:0]    upper_bits;
   logic [IO_BLK_N-1:0]   blk_hit;
   logic                  alias_ok;

   assign ofs        = addr[PORT_OFS_W-1:0];
   assign alias_bits = addr[PORT_W-1:PORT_OFS_W];
   assign upper_bits = addr[ADDR_W-1:PORT_W];

   generate
      for (genvar b = 0; b < IO_BLK_N; b++) begin : g_blk
         assign blk_hit[b] = (ofs >= IO_BLK_LO[b]) && (ofs <= IO_BLK_HI[b]);
      end
   endgenerate

   always_comb begin
      alias_ok = !dec16 || (alias_bits == '0);
      hit      = (upper_bits == '0) && alias_ok && (|blk_hit);
   end

endmodule

// File: rtl/vga_fwd_gate.sv
module vga_fwd_gate
   import vga_fwd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic is_io,
   input  logic from_sec,
   input  logic mem_hit,
   input  logic io_hit,
   input  logic vga_en,
   input  logic io_en,
   input  logic mem_en,
   output vga_verdict_t verdict_q
);

   logic         win_hit;
   logic         kind_en;
   vga_verdict_t verdict_d;

   always_comb begin
      win_hit       = is_io ? io_hit : mem_hit;
      kind_en       = is_io ? io_en : mem_en;
      verdict_d.fwd = valid && vga_en && win_hit && !from_sec && kind_en;
      verdict_d.blk = valid && vga_en && win_hit && from_sec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verdict_q <= '0;
      end else begin
         verdict_q <= verdict_d;
      end
   end

endmodule

// File: rtl/vga_fwd_decoder.sv
module vga_fwd_decoder #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PORT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_is_io,
   input  logic              req_from_sec,
   input  logic              vga_en,
   input  logic              vga_dec16,
   input  logic              cmd_io_en,
   input  logic              cmd_mem_en,
   output logic              fwd_down,
   output logic              block_up
);
   import vga_fwd_pkg::*;

   logic         mem_hit;
   logic         io_hit;
   vga_verdict_t verdict;

   vga_mem_window #(.ADDR_W(ADDR_W)) u_mem (
      .addr (req_addr),
      .hit  (mem_hit)
   );

   vga_io_window #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_io (
      .addr  (req_addr),
      .dec16 (vga_dec16),
      .hit   (io_hit)
   );

   vga_fwd_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (req_valid),
      .is_io     (req_is_io),
      .from_sec  (req_from_sec),
      .mem_hit   (mem_hit),
      .io_hit    (io_hit),
      .vga_en    (vga_en),
      .io_en     (cmd_io_en),
      .mem_en    (cmd_mem_en),
      .verdict_q (verdict)
   );

   assign fwd_down = verdict.fwd;
   assign block_up = verdict.blk;

endmodule

// File: rtl/vga_fwd_chk.sv
module vga_fwd_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PORT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_is_io,
   input logic              req_from_sec,
   input logic              vga_en,
   input logic              vga_dec16,
   input logic              cmd_io_en,
   input logic              cmd_mem_en,
   input logic              fwd_down,
   input logic              block_up
);
   logic frame_addr;
   logic upper_set;
   assign frame_addr = (req_addr >= ADDR_W'(32'h000A_0000)) &&
                       (req_addr <= ADDR_W'(32'h000B_FFFF));
   assign upper_set  = |req_addr[ADDR_W-1:PORT_W];

   // R1: primary memory request inside the frame window is forwarded
   a_r1_mem_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_io && !req_from_sec && vga_en && cmd_mem_en && frame_addr)
      |=> fwd_down);

   // R1: memory request outside the window never acts
   a_r1_mem_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_io && !frame_addr) |=> (!fwd_down && !block_up));

   // R2: I/O request with upper address bits set never acts
   a_r2_io_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_io && upper_set) |=> (!fwd_down && !block_up));

   // R6: disabled kind is not forwarded
   a_r6_kind_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ((req_is_io && !cmd_io_en) || (!req_is_io && !cmd_mem_en)))
      |=> !fwd_down);

   // R7: nothing acts while VGA forwarding is off
   a_r7_vga_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!vga_en) |=> (!fwd_down && !block_up));

   // R8: secondary-originated requests are never forwarded downstream
   a_r8_sec_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (req_from_sec) |=> !fwd_down);

   // R8: the two flags are mutually exclusive
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fwd_down, block_up}));

   // R9: an idle cycle leaves both outputs low after the edge
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid) |=> (!fwd_down && !block_up));

   // R9: outputs are low while reset is held
   always_comb begin
      if (!rst_n) begin
         a_r9_reset: assert (!fwd_down && !block_up);
      end
   end

   logic unused_ok;
   assign unused_ok = &{1'b0, vga_dec16};

endmodule

bind vga_fwd_decoder vga_fwd_chk #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_chk (.*);

// File: tb/sim_vga_fwd_decoder.sv
`timescale 1ns/1ps
module sim_vga_fwd_decoder;

   typedef struct {
      logic  fwd;
      logic  blk;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_is_io = 1'b0;
   logic        req_from_sec = 1'b0;
   logic        vga_en = 1'b0;
   logic        vga_dec16 = 1'b0;
   logic        cmd_io_en = 1'b0;
   logic        cmd_mem_en = 1'b0;
   logic        fwd_down;
   logic        block_up;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #4 clk = ~clk;

   vga_fwd_decoder u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .req_is_io    (req_is_io),
      .req_from_sec (req_from_sec),
      .vga_en       (vga_en),
      .vga_dec16    (vga_dec16),
      .cmd_io_en    (cmd_io_en),
      .cmd_mem_en   (cmd_mem_en),
      .fwd_down     (fwd_down),
      .block_up     (block_up)
   );

   // Expected-value model written from the requirements
   function automatic logic in_window(logic [31:0] a, logic io, logic d16);
      logic [9:0] o;
      o = a[9:0];
      if (!io) return (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
      if (a[31:16] != 16'h0) return 1'b0;
      if (d16 && (a[15:10] != 6'h0)) return 1'b0;
      return ((o >= 10'h3B0) && (o <= 10'h3BB)) || ((o >= 10'h3C0) && (o <= 10'h3DF));
   endfunction

   task automatic check(string tag, logic got_f, logic got_b, logic ex_f, logic ex_b);
      n_checks++;
      if (got_f !== ex_f || got_b !== ex_b) begin
         n_fail++;
         $display("FAIL %s: fwd_down/block_up = %b%b, expected %b%b",
                  tag, got_f, got_b, ex_f, ex_b);
      end
   endtask

   task automatic drive(string tag, logic v, logic [31:0] a, logic io, logic sec,
                        logic en, logic d16, logic ioe, logic meme);
      exp_t e;
      logic h;
      @(negedge clk);
      req_valid = v; req_addr = a; req_is_io = io; req_from_sec = sec;
      vga_en = en; vga_dec16 = d16; cmd_io_en = ioe; cmd_mem_en = meme;
      h     = in_window(a, io, d16);
      e.fwd = v && en && h && !sec && (io ? ioe : meme);
      e.blk = v && en && h && sec;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: compare one expected item per clock, away from the edge
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.tag, fwd_down, block_up, e.fwd, e.blk);
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset", fwd_down, block_up, 1'b0, 1'b0);
      rst_n = 1'b1;

      // R1 memory window edges
      drive("R1 mem low edge",   1, 32'h000A_0000, 0, 0, 1, 0, 1, 1);
      drive("R1 mem high edge",  1, 32'h000B_FFFF, 0, 0, 1, 0, 1, 1);
      drive("R1 mem below",      1, 32'h0009_FFFF, 0, 0, 1, 0, 1, 1);
      drive("R1 mem above",      1, 32'h000C_0000, 0, 0, 1, 0, 1, 1);
      drive("R1 mem high alias", 1, 32'h100A_0000, 0, 0, 1, 0, 1, 1);
      drive("R1 mem at io port", 1, 32'h0000_03C0, 0, 0, 1, 0, 1, 1);
      // R3 I/O port blocks
      drive("R3 io 3B0", 1, 32'h0000_03B0, 1, 0, 1, 0, 1, 1);
      drive("R3 io 3BB", 1, 32'h0000_03BB, 1, 0, 1, 0, 1, 1);
      drive("R3 io 3BC", 1, 32'h0000_03BC, 1, 0, 1, 0, 1, 1);
      drive("R3 io 3BF", 1, 32'h0000_03BF, 1, 0, 1, 0, 1, 1);
      drive("R3 io 3C0", 1, 32'h0000_03C0, 1, 0, 1, 0, 1, 1);
      drive("R3 io 3DF", 1, 32'h0000_03DF, 1, 0, 1, 0, 1, 1);
      drive("R3 io 3E0", 1, 32'h0000_03E0, 1, 0, 1, 0, 1, 1);
      drive("R3 io 3AF", 1, 32'h0000_03AF, 1, 0, 1, 0, 1, 1);
      // R2 upper bits
      drive("R2 io upper bit", 1, 32'h0001_03C0, 1, 0, 1, 0, 1, 1);
      drive("R2 io top bit",   1, 32'h8000_03B4, 1, 0, 1, 0, 1, 1);
      // R4 / R5 aliasing
      drive("R4 alias dec10",     1, 32'h0000_13C0, 1, 0, 1, 0, 1, 1);
      drive("R4 top alias dec10", 1, 32'h0000_FFDF, 1, 0, 1, 0, 1, 1);
      drive("R5 alias dec16",     1, 32'h0000_13C0, 1, 0, 1, 1, 1, 1);
      drive("R5 top alias dec16", 1, 32'h0000_FFDF, 1, 0, 1, 1, 1, 1);
      drive("R5 base dec16",      1, 32'h0000_03C0, 1, 0, 1, 1, 1, 1);
      // R6 command enables
      drive("R6 io no io_en",     1, 32'h0000_03C0, 1, 0, 1, 0, 0, 1);
      drive("R6 io only io_en",   1, 32'h0000_03C0, 1, 0, 1, 0, 1, 0);
      drive("R6 mem no mem_en",   1, 32'h000A_8000, 0, 0, 1, 0, 1, 0);
      drive("R6 mem only mem_en", 1, 32'h000A_8000, 0, 0, 1, 0, 0, 1);
      // R7 vga off
      drive("R7 off mem",   1, 32'h000A_0000, 0, 0, 0, 0, 1, 1);
      drive("R7 off io",    1, 32'h0000_03B0, 1, 0, 0, 1, 1, 1);
      drive("R7 off sec",   1, 32'h0000_03C0, 1, 1, 0, 0, 1, 1);
      // R8 upstream blocking
      drive("R8 sec io match",    1, 32'h0000_03D4, 1, 1, 1, 0, 1, 1);
      drive("R8 sec mem no en",   1, 32'h000B_0000, 0, 1, 1, 0, 0, 0);
      drive("R8 sec io miss",     1, 32'h0000_03E0, 1, 1, 1, 0, 1, 1);
      drive("R8 sec alias dec16", 1, 32'h0000_23C0, 1, 1, 1, 1, 1, 1);
      // R9 idle with a matching address on the bus
      drive("R9 idle match",  0, 32'h000A_0000, 0, 0, 1, 0, 1, 1);
      drive("R9 back to hit", 1, 32'h000A_0000, 0, 0, 1, 0, 1, 1);
      drive("R9 idle sec",    0, 32'h0000_03C0, 1, 1, 1, 0, 1, 1);

      // Mixed patterns
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         case ($urandom_range(0, 3))
            0: a = 32'h000A_0000 + 32'($urandom_range(0, 32'h2_0000)) - 32'h10;
            1: a = {16'h0, 6'($urandom), 10'h3B0 + 10'($urandom_range(0, 63))};
            2: a = {15'h0, 1'($urandom), 16'($urandom)};
            default: a = $urandom;
         endcase
         drive("R1 R3 R6 R8 mixed", 1'($urandom_range(0, 7) != 0), a,
               1'($urandom), 1'($urandom), 1'($urandom_range(0, 5) != 0),
               1'($urandom), 1'($urandom), 1'($urandom));
      end

      drive("R9 final idle", 0, 32'h0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run still active, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule